// File: doc/BRIEF.md
# SIMT Reconvergence Stack Controller

This block tracks which threads of a warp are live while the warp runs through divergent branches. The execute stage gives it one operation per warp instruction. Each operation carries a small function code and, where the code needs them, a per-thread predicate vector, the PC that follows the instruction, or a mask argument. A split that divides the live threads saves enough context on a bounded stack for both paths to be replayed. The threads whose predicate is false run first. The join at the end of that path sends the warp back to the saved PC with the predicate-true threads. A second join restores the mask that held before the split.

When every live thread agrees on its predicate, a split pushes only one entry, marked uniform. The join that matches it restores the mask and does not redirect. All state changes and pulse outputs are registered. They are visible in the cycle after the operation is presented. Stack overflow, stack underflow and a split issued with no live thread are each reported on a one-cycle error pulse, and none of them changes any state.

Top module: `simt_reconv_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the thread mask to thread 0 only (value 1), empties the stack, and clears the redirect and error outputs. A join issued right after reset reports underflow.
- R2: An operation is decoded only while `opValid` is high. Function code 2 is a split, code 3 is a join, and code 0 loads `maskArg` into the thread mask. Every other code, and any code while `opValid` is low, leaves the mask, the stack and the pulse outputs unchanged.
- R3: A split is uniform when the predicate bits of the live threads are all 1 or all 0. A uniform split leaves the mask unchanged and pushes one uniform entry holding that mask. The join that pops it restores the saved mask and raises no redirect.
- R4: A divergent split pushes a fall-through entry holding the current mask, then an entry holding the live predicate-true threads and `nextPc`. The new mask is the old mask AND the inverted predicate. It is visible one cycle after the split.
- R5: A join whose top entry is neither uniform nor fall-through raises `redirectValid` for one cycle with `redirectPc` equal to the saved PC. The mask becomes the saved predicate-true threads, and the entry is popped.
- R6: A join whose top entry is a fall-through entry restores the saved mask, pops the entry and raises no redirect.
- R7: A split issued while the mask is zero raises `errNoActive` for one cycle and changes nothing.
- R8: A uniform split on a full stack, or a divergent split with fewer than two free slots, raises `errOverflow` for one cycle and changes neither the mask nor the stack. Only one error pulse is high at a time.
- R9: A join on an empty stack raises `errUnderflow` for one cycle and leaves the mask unchanged.
- R10: Nested splits unwind in last-in, first-out order. Each join restores the entries of the innermost open split first.
- R11: Predicate bits of threads outside the current mask play no part in deciding whether a split is uniform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation present this cycle |
| opFunc | input | 3 | Function code: 0 mask load, 2 split, 3 join |
| predVec | input | NT | Per-thread predicate for a split |
| nextPc | input | PC_W | PC following the split |
| maskArg | input | NT | Mask value for a mask load |
| threadMask | output | NT | Current live-thread mask |
| redirectValid | output | 1 | One-cycle pulse: fetch must jump to redirectPc |
| redirectPc | output | PC_W | Redirect target |
| errOverflow | output | 1 | Push refused, stack too full |
| errUnderflow | output | 1 | Join on empty stack |
| errNoActive | output | 1 | Split with no live thread |

## Verification
The stimulus starts with splits whose predicate divides a full mask. It then nests a second divergent split inside the first, so the order in which the joins unwind separates a correct stack from one that pops in the wrong order. A split whose predicate disagrees only on inactive threads must be classed as uniform. This separates a design that masks the predicate from one that does not. It also proves that the matching join does not redirect, because a mask load in between makes the restored value differ from the value current at the time of the join. The stack is filled to exactly one free slot and then to full. A divergent push must then be refused while a uniform push is still accepted. Unused function codes, a deasserted valid, a join on an empty stack and a split with a zero mask must each leave the observable state unchanged.

// File: rtl/reconv_pkg.sv
package reconv_pkg;
  localparam logic [2:0] FN_MASKSET = 3'd0;
  localparam logic [2:0] FN_SPLIT   = 3'd2;
  localparam logic [2:0] FN_JOIN    = 3'd3;

  typedef struct packed {
    logic pushUni;
    logic pushDiv;
    logic popTop;
    logic redirect;
    logic loadMask;
    logic errOvf;
    logic errUnf;
    logic errIdle;
  } stackCmd_t;
endpackage

// File: rtl/reconv_ctrl.sv
module reconv_ctrl
  import reconv_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic          opValid,
  input  logic [2:0]    opFunc,
  input  logic [NT-1:0] curMask,
  input  logic [NT-1:0] predVec,
  input  logic          stackEmpty,
  input  logic          roomOne,
  input  logic          roomTwo,
  input  logic          topUni,
  input  logic          topFt,
  output stackCmd_t     cmd
);
  logic [NT-1:0] livePred;
  logic          isUniform;

  assign livePred  = predVec & curMask;
  assign isUniform = (livePred == '0) || (livePred == curMask);

  always_comb begin
    cmd = '0;
    if (opValid) begin
      case (opFunc)
        FN_SPLIT: begin
          if (curMask == '0) cmd.errIdle = 1'b1;
          else if (isUniform) begin
            if (roomOne) cmd.pushUni = 1'b1;
            else         cmd.errOvf  = 1'b1;
          end else begin
            if (roomTwo) cmd.pushDiv = 1'b1;
            else         cmd.errOvf  = 1'b1;
          end
        end
        FN_JOIN: begin
          if (stackEmpty) cmd.errUnf = 1'b1;
          else begin
            cmd.popTop   = 1'b1;
            cmd.redirect = !topUni && !topFt;
          end
        end
        FN_MASKSET: cmd.loadMask = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/reconv_datapath.sv
module reconv_datapath
  import reconv_pkg::*;
#(
  parameter int NT    = 4,
  parameter int DEPTH = 4,
  parameter int PC_W  = 32,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  stackCmd_t       cmd,
  input  logic [NT-1:0]   predVec,
  input  logic [PC_W-1:0] nextPc,
  input  logic [NT-1:0]   maskArg,
  output logic [NT-1:0]   curMask,
  output logic [SP_W-1:0] level,
  output logic            stackEmpty,
  output logic            roomOne,
  output logic            roomTwo,
  output logic            topUni,
  output logic            topFt,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  output logic            errOverflow,
  output logic            errUnderflow,
  output logic            errNoActive
);
  logic [NT-1:0]   slotMask [DEPTH];
  logic [PC_W-1:0] slotPc   [DEPTH];
  logic            slotUni  [DEPTH];
  logic            slotFt   [DEPTH];
  logic [IDX_W-1:0] topIdx;

  assign topIdx     = IDX_W'(level - SP_W'(1));
  assign stackEmpty = (level == '0);
  assign roomOne    = ({1'b0, level} < (SP_W+1)'(DEPTH));
  assign roomTwo    = ({1'b0, level} + (SP_W+1)'(2) <= (SP_W+1)'(DEPTH));
  assign topUni     = slotUni[topIdx];
  assign topFt      = slotFt[topIdx];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (cmd.pushUni && level == SP_W'(g)) begin
        slotMask[g] <= curMask;
        slotPc[g]   <= nextPc;
        slotUni[g]  <= 1'b1;
        slotFt[g]   <= 1'b1;
      end else if (cmd.pushDiv && level == SP_W'(g)) begin
        slotMask[g] <= curMask;
        slotPc[g]   <= nextPc;
        slotUni[g]  <= 1'b0;
        slotFt[g]   <= 1'b1;
      end else if (cmd.pushDiv && level + SP_W'(1) == SP_W'(g)) begin
        slotMask[g] <= curMask & predVec;
        slotPc[g]   <= nextPc;
        slotUni[g]  <= 1'b0;
        slotFt[g]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curMask       <= NT'(1);
      level         <= '0;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      errOverflow   <= 1'b0;
      errUnderflow  <= 1'b0;
      errNoActive   <= 1'b0;
    end else begin
      redirectValid <= cmd.redirect;
      errOverflow   <= cmd.errOvf;
      errUnderflow  <= cmd.errUnf;
      errNoActive   <= cmd.errIdle;
      if (cmd.redirect) redirectPc <= slotPc[topIdx];
      if (cmd.pushUni) begin
        level <= level + SP_W'(1);
      end else if (cmd.pushDiv) begin
        level   <= level + SP_W'(2);
        curMask <= curMask & ~predVec;
      end else if (cmd.popTop) begin
        level   <= level - SP_W'(1);
        curMask <= slotMask[topIdx];
      end else if (cmd.loadMask) begin
        curMask <= maskArg;
      end
    end
  end
endmodule

// File: rtl/simt_reconv_ctrl.sv
module simt_reconv_ctrl
  import reconv_pkg::*;
#(
  parameter int NT    = 4,
  parameter int DEPTH = 4,
  parameter int PC_W  = 32,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            opValid,
  input  logic [2:0]      opFunc,
  input  logic [NT-1:0]   predVec,
  input  logic [PC_W-1:0] nextPc,
  input  logic [NT-1:0]   maskArg,
  output logic [NT-1:0]   threadMask,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  output logic            errOverflow,
  output logic            errUnderflow,
  output logic            errNoActive
);
  stackCmd_t       cmd;
  logic [SP_W-1:0] stackLevel;
  logic            stackEmpty, roomOne, roomTwo, topUni, topFt;

  reconv_ctrl #(.NT(NT)) u_ctrl (
    .opValid(opValid), .opFunc(opFunc), .curMask(threadMask), .predVec(predVec),
    .stackEmpty(stackEmpty), .roomOne(roomOne), .roomTwo(roomTwo),
    .topUni(topUni), .topFt(topFt), .cmd(cmd)
  );

  reconv_datapath #(.NT(NT), .DEPTH(DEPTH), .PC_W(PC_W)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .predVec(predVec), .nextPc(nextPc),
    .maskArg(maskArg), .curMask(threadMask), .level(stackLevel),
    .stackEmpty(stackEmpty), .roomOne(roomOne), .roomTwo(roomTwo),
    .topUni(topUni), .topFt(topFt), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .errOverflow(errOverflow),
    .errUnderflow(errUnderflow), .errNoActive(errNoActive)
  );
endmodule

// File: rtl/reconv_checker.sv
module reconv_checker #(
  parameter int NT    = 4,
  parameter int DEPTH = 4,
  parameter int SP_W  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            opValid,
  input logic [2:0]      opFunc,
  input logic [NT-1:0]   threadMask,
  input logic [SP_W-1:0] stackLevel,
  input logic            redirectValid,
  input logic            errOverflow,
  input logic            errUnderflow,
  input logic            errNoActive
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (threadMask == NT'(1) && stackLevel == '0)); // R1

  AST_IGNORED_CODE: assert property (@(posedge clk) disable iff (rst)
    (opValid && opFunc != 3'd0 && opFunc != 3'd2 && opFunc != 3'd3)
      |=> ($stable(threadMask) && $stable(stackLevel))); // R2

  AST_REDIRECT_FROM_JOIN: assert property (@(posedge clk) disable iff (rst)
    redirectValid |-> ($past(opValid) && $past(opFunc) == 3'd3)); // R5

  AST_IDLE_SPLIT: assert property (@(posedge clk) disable iff (rst)
    errNoActive |-> (threadMask == '0 && $stable(stackLevel))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    errOverflow |-> ($stable(threadMask) && $stable(stackLevel))); // R8

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
    $onehot0({errOverflow, errUnderflow, errNoActive})); // R8

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    stackLevel <= SP_W'(DEPTH)); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    errUnderflow |-> ($stable(threadMask) && stackLevel == '0)); // R9
endmodule

bind simt_reconv_ctrl reconv_checker #(.NT(NT), .DEPTH(DEPTH), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .opValid(opValid), .opFunc(opFunc),
  .threadMask(threadMask), .stackLevel(stackLevel),
  .redirectValid(redirectValid), .errOverflow(errOverflow),
  .errUnderflow(errUnderflow), .errNoActive(errNoActive)
);

// File: tb/test_simt_reconv_ctrl.sv
module test_simt_reconv_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [2:0]  opFunc = 3'd0;
  logic [3:0]  predVec = '0;
  logic [31:0] nextPc = '0;
  logic [3:0]  maskArg = '0;
  logic [3:0]  threadMask;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        errOverflow, errUnderflow, errNoActive;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  simt_reconv_ctrl #(.NT(4), .DEPTH(4), .PC_W(32)) i_simt_reconv_ctrl (
    .clk(clk), .rst(rst), .opValid(opValid), .opFunc(opFunc), .predVec(predVec),
    .nextPc(nextPc), .maskArg(maskArg), .threadMask(threadMask),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .errOverflow(errOverflow), .errUnderflow(errUnderflow), .errNoActive(errNoActive)
  );

  typedef struct packed {
    logic [2:0]  fn;
    logic [3:0]  pred;
    logic [31:0] pc;
    logic [3:0]  marg;
    logic [3:0]  eMask;
    logic        eRv;
    logic [31:0] eRpc;
    logic        eOvf;
    logic        eUnf;
    logic        eIdle;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'h0, 32'h0,   4'hF, 4'hF, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd2},  // R2 mask load
    '{3'd2, 4'h3, 32'h100, 4'h0, 4'hC, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd4},  // R4 divergent
    '{3'd2, 4'h4, 32'h200, 4'h0, 4'h8, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd10}, // R10 nested
    '{3'd2, 4'hF, 32'h0,   4'h0, 4'h8, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 8'd8},  // R8 full
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'h4, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 inner
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'hC, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd6},  // R6 inner
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'h3, 1'b1, 32'h100, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 outer
    '{3'd2, 4'h1, 32'h300, 4'h0, 4'h2, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd4},  // R4
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'h1, 1'b1, 32'h300, 1'b0, 1'b0, 1'b0, 8'd5},  // R5
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'h3, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd6},  // R6
    '{3'd2, 4'hC, 32'h0,   4'h0, 4'h3, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd11}, // R11 uniform
    '{3'd5, 4'h0, 32'h0,   4'h0, 4'h3, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd2},  // R2 unused code
    '{3'd0, 4'h0, 32'h0,   4'h0, 4'h0, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd2},  // R2 zero mask
    '{3'd2, 4'hF, 32'h0,   4'h0, 4'h0, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 8'd7},  // R7
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'h3, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd3},  // R3 uniform pop
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'hF, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd6},  // R6 outer
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'hF, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 8'd9},  // R9
    '{3'd2, 4'h5, 32'h400, 4'h0, 4'hA, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd4},  // R4
    '{3'd1, 4'h0, 32'h0,   4'h3, 4'hA, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd2},  // R2 code 1
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'h5, 1'b1, 32'h400, 1'b0, 1'b0, 1'b0, 8'd5},  // R5
    '{3'd3, 4'h0, 32'h0,   4'h0, 4'hF, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd6}   // R6
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input logic [3:0] m, input logic rv,
                          input logic [31:0] rpc, input logic ovf, input logic unf,
                          input logic idle);
    check(req, "mask", 32'(threadMask), 32'(m));
    check(req, "redirectValid", 32'(redirectValid), 32'(rv));
    if (rv) check(req, "redirectPc", redirectPc, rpc);
    check(req, "errOverflow", 32'(errOverflow), 32'(ovf));
    check(req, "errUnderflow", 32'(errUnderflow), 32'(unf));
    check(req, "errNoActive", 32'(errNoActive), 32'(idle));
  endtask

  task automatic doOp(input logic v, input logic [2:0] fn, input logic [3:0] p,
                      input logic [31:0] pc, input logic [3:0] m);
    @(negedge clk);
    opValid = v; opFunc = fn; predVec = p; nextPc = pc; maskArg = m;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state
    checkAll("R1", 4'h1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      doOp(1'b1, VECS[i].fn, VECS[i].pred, VECS[i].pc, VECS[i].marg);
      checkAll($sformatf("R%0d", VECS[i].req), VECS[i].eMask, VECS[i].eRv,
               VECS[i].eRpc, VECS[i].eOvf, VECS[i].eUnf, VECS[i].eIdle);
    end

    // R8: one free slot refuses a divergent split, but accepts a uniform one
    doOp(1'b1, 3'd0, 4'h0, 32'h0, 4'hF);
    doOp(1'b1, 3'd2, 4'h3, 32'h500, 4'h0);
    checkAll("R4", 4'hC, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    doOp(1'b1, 3'd2, 4'hF, 32'h0, 4'h0);
    checkAll("R3", 4'hC, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    doOp(1'b1, 3'd2, 4'h4, 32'h600, 4'h0);
    checkAll("R8", 4'hC, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    doOp(1'b1, 3'd2, 4'h0, 32'h0, 4'h0);
    checkAll("R8", 4'hC, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

    // R2: valid low leaves everything unchanged
    doOp(1'b0, 3'd3, 4'h0, 32'h0, 4'h0);
    checkAll("R2", 4'hC, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

    // R10: unwind uniform, uniform, then the divergent pair
    doOp(1'b1, 3'd3, 4'h0, 32'h0, 4'h0);
    checkAll("R3", 4'hC, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    doOp(1'b1, 3'd3, 4'h0, 32'h0, 4'h0);
    checkAll("R3", 4'hC, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    doOp(1'b1, 3'd3, 4'h0, 32'h0, 4'h0);
    checkAll("R10", 4'h3, 1'b1, 32'h500, 1'b0, 1'b0, 1'b0);

    // R1: reset with entries on the stack empties it
    doReset();
    checkAll("R1", 4'h1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    doOp(1'b1, 3'd3, 4'h0, 32'h0, 4'h0);
    checkAll("R1", 4'h1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule